// File: doc/BRIEF.md
# Byte-Serial 16-bit MOV Decoder

This block takes an instruction stream one byte at a time and turns each 16-bit MOV instruction into a single decoded record. The record holds a legality flag and a destination and a source operand descriptor. It also holds the memory selector, the displacement, the immediate and the total byte length of the instruction.

The first byte is looked up in a small table. The table gives the instruction's attributes: whether it has a ModRM byte, a direction bit, an implicit accumulator, a register coded in the opcode, a 16-bit offset and a 16-bit immediate. These attributes steer the byte sequencing and how the two operands are placed. Any opcode outside the supported set, or the immediate form with a nonzero extension field, gives an illegal record.

Input bytes are offered with a valid/ready pair. The record is presented with `out_valid` and stays held until the consumer raises `out_ready`. The decoder takes the next opcode on the cycle after that handoff.

Top module: `mov16_decoder`

## Requirements
- R1: Opcode 0x89 reads a ModRM byte: the destination is the r/m operand and the source is REG with the number in ModRM bits 5:3.
- R2: Opcode 0x8B equals 0x89 with both operands exchanged: the destination is REG (ModRM bits 5:3) and the source is the r/m operand.
- R3: Opcodes 0xB8..0xBF give destination REG number opcode[2:0] and source IMM, taken from the next two bytes low byte first. The length is 3.
- R4: Opcode 0xA1 gives destination REG 0 and source DIRECT, with the offset from the next two bytes low byte first. The length is 3.
- R5: Opcode 0xA3 gives destination DIRECT (offset low byte first) and source REG 0. The length is 3.
- R6: Opcode 0xC7 with ModRM bits 5:3 equal to 0 gives destination r/m operand and source IMM. The immediate is the two bytes after the ModRM and displacement bytes, low byte first.
- R7: Opcode 0xC7 with nonzero ModRM bits 5:3 gives a record with legal=0, length 1 and all descriptor, selector, displacement and immediate fields zero, as soon as the ModRM byte is taken.
- R8: Any other first byte gives at once a record with legal=0, length 1 and all descriptor fields zero.
- R9: The r/m operand depends on ModRM mod (bits 7:6) and rm (bits 2:0). mod=3 gives REG rm. mod=0 with rm=6 gives DIRECT with a 16-bit displacement. Other mod=0 cases give MEM with displacement 0. mod=1 gives MEM with an 8-bit sign-extended displacement. mod=2 gives MEM with a 16-bit displacement, low byte first. For MEM, `out_mem_sel` equals rm.
- R10: Operand kind codes are 0=REG, 1=MEM, 2=DIRECT, 3=IMM. The reported length counts the opcode, ModRM, displacement and immediate bytes.
- R11: While `out_valid` is high, `in_ready` is low and the record is held stable. After a cycle with `out_ready` high, `in_ready` is high on the next cycle.
- R12: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder takes a byte this cycle |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_legal | output | 1 | Instruction is in the supported set |
| out_dst_kind | output | 2 | Destination kind (0 REG, 1 MEM, 2 DIRECT, 3 IMM) |
| out_dst_reg | output | 3 | Destination register number when REG |
| out_src_kind | output | 2 | Source kind |
| out_src_reg | output | 3 | Source register number when REG |
| out_mem_sel | output | 3 | Base/index selector for a MEM operand |
| out_disp | output | 16 | Displacement or direct offset |
| out_imm | output | 16 | Immediate value |
| out_len | output | 3 | Instruction length in bytes |

## Verification
The assertions assume that `in_valid` is driven only between instructions or while the decoder waits for a byte. They also assume that `out_ready` is raised only while a record is shown. The bench offers each byte away from the clock edge and waits for `in_ready` before it does. It raises `out_ready` for a single cycle only after it has checked the record. For that reason every byte boundary and every handoff falls on a clean edge. The stimulus also covers every mod value and the direct-address exception.

// File: rtl/mov16_decoder.sv
module mov16_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_legal,
  output logic [1:0]  out_dst_kind,
  output logic [2:0]  out_dst_reg,
  output logic [1:0]  out_src_kind,
  output logic [2:0]  out_src_reg,
  output logic [2:0]  out_mem_sel,
  output logic [15:0] out_disp,
  output logic [15:0] out_imm,
  output logic [2:0]  out_len
);
  localparam logic [1:0] K_REG = 2'd0, K_MEM = 2'd1, K_DIR = 2'd2, K_IMM = 2'd3;

  typedef enum logic [2:0] {S_OP, S_MRM, S_DSP, S_IMM, S_OUT} st_t;
  st_t st;

  logic [7:0]  opc, mrm;
  logic [15:0] disp, imm;
  logic [2:0]  len;
  logic [1:0]  dsz, dcnt;
  logic        icnt, legal;
  logic        f_mrm, f_dir, f_ax, f_rop, f_imm, f_off;

  // first-byte attribute table
  logic t_ok, t_mrm, t_dir, t_ax, t_rop, t_imm, t_off;
  always_comb begin
    {t_ok, t_mrm, t_dir, t_ax, t_rop, t_imm, t_off} = '0;
    case (in_byte)
      8'h89: {t_ok, t_mrm} = 2'b11;
      8'h8B: {t_ok, t_mrm, t_dir} = 3'b111;
      8'hA1: {t_ok, t_ax, t_off, t_dir} = 4'b1111;
      8'hA3: {t_ok, t_ax, t_off} = 3'b111;
      8'hC7: {t_ok, t_mrm, t_imm} = 3'b111;
      default: if (in_byte[7:3] == 5'b10111) {t_ok, t_rop, t_imm} = 3'b111;
    endcase
  end

  logic       take;
  logic [1:0] m_dsz;
  assign in_ready  = (st != S_OUT);
  assign out_valid = (st == S_OUT);
  assign take      = in_valid && in_ready;

  always_comb begin
    case (in_byte[7:6])
      2'd0:    m_dsz = (in_byte[2:0] == 3'd6) ? 2'd2 : 2'd0;
      2'd1:    m_dsz = 2'd1;
      2'd2:    m_dsz = 2'd2;
      default: m_dsz = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OP; opc <= '0; mrm <= '0; disp <= '0; imm <= '0; len <= '0;
      dsz <= '0; dcnt <= '0; icnt <= 1'b0; legal <= 1'b0;
      {f_mrm, f_dir, f_ax, f_rop, f_imm, f_off} <= '0;
    end else begin
      case (st)
        S_OP: if (take) begin
          opc <= in_byte; mrm <= '0; disp <= '0; imm <= '0; len <= 3'd1;
          dcnt <= '0; icnt <= 1'b0; legal <= t_ok;
          dsz <= t_off ? 2'd2 : 2'd0;
          {f_mrm, f_dir, f_ax, f_rop, f_imm, f_off} <= {t_mrm, t_dir, t_ax, t_rop, t_imm, t_off};
          if (!t_ok)      st <= S_OUT;
          else if (t_mrm) st <= S_MRM;
          else if (t_off) st <= S_DSP;
          else            st <= S_IMM;
        end
        S_MRM: if (take) begin
          if (opc == 8'hC7 && in_byte[5:3] != 3'd0) begin
            legal <= 1'b0;
            {f_mrm, f_dir, f_ax, f_rop, f_imm, f_off} <= '0;
            st <= S_OUT;
          end else begin
            mrm <= in_byte;
            len <= len + 3'd1;
            dsz <= m_dsz;
            if (m_dsz != 2'd0) st <= S_DSP;
            else if (f_imm)    st <= S_IMM;
            else               st <= S_OUT;
          end
        end
        S_DSP: if (take) begin
          len <= len + 3'd1;
          if (dcnt == 2'd0) disp <= (dsz == 2'd1) ? {{8{in_byte[7]}}, in_byte} : {8'h00, in_byte};
          else              disp[15:8] <= in_byte;
          dcnt <= dcnt + 2'd1;
          if (dcnt + 2'd1 == dsz) st <= f_imm ? S_IMM : S_OUT;
        end
        S_IMM: if (take) begin
          len <= len + 3'd1;
          icnt <= 1'b1;
          if (!icnt) imm[7:0] <= in_byte;
          else begin
            imm[15:8] <= in_byte;
            st <= S_OUT;
          end
        end
        S_OUT: if (out_ready) st <= S_OP;
        default: st <= S_OP;
      endcase
    end
  end

  // r/m side operand
  logic [1:0] a_kind, b_kind;
  logic [2:0] a_reg, b_reg;
  always_comb begin
    if (!f_mrm)                                   a_kind = K_DIR;
    else if (mrm[7:6] == 2'd3)                    a_kind = K_REG;
    else if (mrm[7:6] == 2'd0 && mrm[2:0] == 3'd6) a_kind = K_DIR;
    else                                          a_kind = K_MEM;
  end
  assign a_reg  = (a_kind == K_REG) ? mrm[2:0] : 3'd0;
  assign b_kind = f_imm ? K_IMM : K_REG;
  assign b_reg  = f_imm ? 3'd0 : (f_ax ? 3'd0 : mrm[5:3]);

  always_comb begin
    if (!legal) begin
      out_dst_kind = K_REG; out_dst_reg = '0; out_src_kind = K_REG; out_src_reg = '0;
    end else if (f_rop) begin
      out_dst_kind = K_REG; out_dst_reg = opc[2:0]; out_src_kind = K_IMM; out_src_reg = '0;
    end else if (f_dir) begin
      out_dst_kind = b_kind; out_dst_reg = b_reg; out_src_kind = a_kind; out_src_reg = a_reg;
    end else begin
      out_dst_kind = a_kind; out_dst_reg = a_reg; out_src_kind = b_kind; out_src_reg = b_reg;
    end
  end

  assign out_legal   = legal;
  assign out_mem_sel = (legal && f_mrm && a_kind == K_MEM) ? mrm[2:0] : 3'd0;
  assign out_disp    = legal ? disp : 16'h0;
  assign out_imm     = legal ? imm : 16'h0;
  assign out_len     = len;
endmodule

module mov16_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_legal,
  input logic [1:0] out_dst_kind,
  input logic [1:0] out_src_kind,
  input logic [2:0] out_len,
  input logic [15:0] out_disp,
  input logic [15:0] out_imm
);
  AST_NO_INPUT_WHILE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R11
  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_legal)
      && $stable(out_disp) && $stable(out_imm)); // R11
  AST_READY_AFTER_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid); // R11
  AST_ILLEGAL_LEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_legal |-> out_len == 3'd1); // R7
  AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_legal |-> out_len >= 3'd2 && out_len <= 3'd6); // R10
  AST_ONE_IMM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_dst_kind == 2'd3)); // R6
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_legal |-> out_dst_kind == 2'd0 && out_src_kind == 2'd0 && out_imm == 16'h0); // R8
endmodule

bind mov16_decoder mov16_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_legal(out_legal), .out_dst_kind(out_dst_kind),
  .out_src_kind(out_src_kind), .out_len(out_len), .out_disp(out_disp), .out_imm(out_imm)
);

// File: tb/mov16_decoder_tb_top.sv
`timescale 1ns/1ps
module mov16_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid, out_legal;
  logic [1:0] out_dst_kind, out_src_kind;
  logic [2:0] out_dst_reg, out_src_reg, out_mem_sel, out_len;
  logic [15:0] out_disp, out_imm;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mov16_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_legal(out_legal),
    .out_dst_kind(out_dst_kind), .out_dst_reg(out_dst_reg), .out_src_kind(out_src_kind),
    .out_src_reg(out_src_reg), .out_mem_sel(out_mem_sel), .out_disp(out_disp),
    .out_imm(out_imm), .out_len(out_len)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_rec(input string tag, input logic lg, input logic [1:0] dk, input logic [2:0] dr,
                            input logic [1:0] sk, input logic [2:0] sr, input logic [2:0] ms,
                            input logic [15:0] dp, input logic [15:0] im, input logic [2:0] ln);
    logic [47:0] act, exp;
    int n = 0;
    while (!out_valid && n < 20) begin @(negedge clk); n++; end
    act = {out_legal, out_dst_kind, out_dst_reg, out_src_kind, out_src_reg, out_mem_sel, out_disp, out_imm, out_len};
    exp = {lg, dk, dr, sk, sr, ms, dp, im, ln};
    chk(out_valid === 1'b1, {tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(act === exp, tag, {16'd0, act}, {16'd0, exp});
    @(negedge clk);
    chk(in_ready === 1'b0 && out_len === ln && out_disp === dp, "R11 hold", {61'd0, in_ready, out_len}, {61'd0, 1'b0, ln});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R11 ready after handoff", {62'd0, in_ready, out_valid}, 64'd2);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R12 reset", {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  task automatic t_89();
    push(8'h89); push(8'hD9);
    expect_rec("R1 89 reg-reg", 1, 0, 1, 0, 3, 0, 16'h0, 16'h0, 2);
    push(8'h89); push(8'h0B);
    expect_rec("R1 R9 89 mod0 mem", 1, 1, 0, 0, 1, 3, 16'h0, 16'h0, 2);
    push(8'h89); push(8'h06); push(8'h34); push(8'h12);
    expect_rec("R9 89 direct disp16", 1, 2, 0, 0, 0, 0, 16'h1234, 16'h0, 4);
    push(8'h89); push(8'hAA); push(8'h78); push(8'h56);
    expect_rec("R9 R10 89 mod2 disp16", 1, 1, 0, 0, 5, 2, 16'h5678, 16'h0, 4);
  endtask

  task automatic t_8b();
    push(8'h8B); push(8'h57); push(8'hF0);
    expect_rec("R2 R9 8B mod1 sext", 1, 0, 2, 1, 0, 7, 16'hFFF0, 16'h0, 3);
    push(8'h8B); push(8'h45); push(8'h12);
    expect_rec("R2 R9 8B mod1 positive", 1, 0, 0, 1, 0, 5, 16'h0012, 16'h0, 3);
  endtask

  task automatic t_rop();
    push(8'hBB); push(8'h34); push(8'h12);
    expect_rec("R3 BB imm", 1, 0, 3, 3, 0, 0, 16'h0, 16'h1234, 3);
    push(8'hB8); push(8'hFF); push(8'h00);
    expect_rec("R3 B8 imm", 1, 0, 0, 3, 0, 0, 16'h0, 16'h00FF, 3);
    push(8'hBF); push(8'h01); push(8'h80);
    expect_rec("R3 BF imm", 1, 0, 7, 3, 0, 0, 16'h0, 16'h8001, 3);
  endtask

  task automatic t_acc();
    push(8'hA1); push(8'hCD); push(8'hAB);
    expect_rec("R4 A1 load", 1, 0, 0, 2, 0, 0, 16'hABCD, 16'h0, 3);
    push(8'hA3); push(8'h01); push(8'h80);
    expect_rec("R5 A3 store", 1, 2, 0, 0, 0, 0, 16'h8001, 16'h0, 3);
  endtask

  task automatic t_c7();
    push(8'hC7); push(8'h82); push(8'h10); push(8'h00); push(8'hEF); push(8'hBE);
    expect_rec("R6 R10 C7 mod2", 1, 1, 0, 3, 0, 2, 16'h0010, 16'hBEEF, 6);
    push(8'hC7); push(8'hC6); push(8'h55); push(8'hAA);
    expect_rec("R6 C7 reg", 1, 0, 6, 3, 0, 0, 16'h0, 16'hAA55, 4);
    push(8'hC7); push(8'h08);
    expect_rec("R7 C7 bad ext", 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 1);
    push(8'hC7); push(8'hB8);
    expect_rec("R7 C7 bad ext 7", 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 1);
  endtask

  task automatic t_bad();
    push(8'h90);
    expect_rec("R8 0x90", 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 1);
    push(8'h8A);
    expect_rec("R8 0x8A", 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 1);
    push(8'hB9); push(8'h22); push(8'h11);
    expect_rec("R3 after illegal", 1, 0, 1, 3, 0, 0, 16'h0, 16'h1122, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_89();
    t_8b();
    t_rop();
    t_acc();
    t_c7();
    t_bad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule